// File: doc/BRIEF.md
# GPIO Port with Peripheral Override

This block is an eight-pin general-purpose I/O port. Software sees four byte-wide locations on a simple synchronous bus: a direction register, an output latch, a port data readback and a raw pin readback. Each pin's output enable and driven value come from a per-pin priority selector. An enabled PWM channel or an enabled SPI function can take over a pin. When neither does, the direction register bit and the output latch control the pin.

One PWM channel has a shutdown option. When that channel is enabled and shutdown is active, its pin becomes an input. Pin levels pass through a two-stage synchronizer before the bus can read them, so a pin change shows up on a read two clock edges after it is sampled. Which pins the SPI function may claim is set by a parameter mask. Which pin carries the shutdown channel is also a parameter.

Top module: `gpio_ovr_port`

## Requirements
- R1: The direction register sits at bus address 0. It reads back the last value written and resets to 0x00. While it is 0x00 and no peripheral overrides any pin, every `pin_oe` bit is low.
- R2: The output latch sits at bus address 1. It reads back the last value written and resets to 0x00.
- R3: When no peripheral overrides a pin, its `pin_oe` bit equals its direction bit (1 = output, 0 = input). An output pin drives the matching output latch bit.
- R4: When `pwm_en[i]` is high, pin i is an output driving `pwm_out[i]`, whatever the direction register holds. The only exception is the shutdown case in R5.
- R5: When `pwm_en[SHUT_PIN]` and `pwm_shut` are both high, pin SHUT_PIN is an input. `pwm_shut` has no effect on any other pin.
- R6: When `spi_en` is high, each pin in `SPI_PIN_MASK` takes its direction from `spi_dir` and its value from `spi_out`. Pins outside the mask are unaffected. An enabled PWM channel wins over SPI on the same pin.
- R7: When a pin's overriding peripheral is disabled, the pin's direction and value return to the direction register and the output latch.
- R8: Bus address 3 returns the synchronized pin levels. A change on `pin_in` appears on a read after exactly two rising clock edges and not after one.
- R9: Bus address 2 returns, per pin, the output latch bit when the pin's effective `pin_oe` is high, and the synchronized pin level when it is low.
- R10: Writes to addresses 2 and 3 change neither the direction register nor the output latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register select (0 dir, 1 out latch, 2 port data, 3 pin level) |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected address (combinational) |
| pin_in | input | 8 | Asynchronous pin levels |
| pin_oe | output | 8 | Per-pin output enable |
| pin_out | output | 8 | Per-pin driven value |
| pwm_en | input | 8 | Per-channel PWM enable |
| pwm_out | input | 8 | Per-channel PWM waveform |
| pwm_shut | input | 1 | Shutdown request for the designated PWM channel |
| spi_en | input | 1 | SPI function enable |
| spi_dir | input | 8 | SPI-requested direction per pin |
| spi_out | input | 8 | SPI-requested value per pin |

## Verification
The assertions assume that the peripheral enables are steady at the sampling edge and that `pin_in` stays valid once reset has been released. The latency property also assumes that `pin_in` is sampled cleanly, with no metastable resolution changing a bit. The stimulus changes every input only on falling clock edges and holds each level for at least one full cycle, so every synchronizer sample is unambiguous. Override scenarios are applied one combination at a time and checked before the next combination is applied.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;

   typedef enum logic [1:0] {
      REG_DIR  = 2'd0,
      REG_OUT  = 2'd1,
      REG_PORT = 2'd2,
      REG_PIN  = 2'd3
   } gpio_reg_e;

   localparam int unsigned ADDR_W = 2;

endpackage

// File: rtl/gpio_ovr_regs.sv
module gpio_ovr_regs
   import gpio_ovr_pkg::*;
#(
   parameter int unsigned NP = 8,
   parameter int unsigned DW = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   input  logic [DW-1:0]     wdata,
   output logic [NP-1:0]     dir_q,
   output logic [NP-1:0]     out_q
);

   logic wr_dir, wr_out;

   assign wr_dir = we && (addr == REG_DIR);
   assign wr_out = we && (addr == REG_OUT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dir_q <= '0;
         out_q <= '0;
      end else begin
         if (wr_dir) dir_q <= wdata[NP-1:0];
         if (wr_out) out_q <= wdata[NP-1:0];
      end
   end

   // R1: a direction write lands on the next edge
   assert_dir_write_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == REG_DIR) |=> (dir_q == $past(wdata[NP-1:0])));

   // R10: read-only locations leave the storage untouched
   assert_ro_ignored_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      (we && (addr == REG_PORT || addr == REG_PIN)) |=> ($stable(dir_q) && $stable(out_q)));

endmodule

// File: rtl/gpio_ovr_sync.sv
module gpio_ovr_sync #(
   parameter int unsigned NP     = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NP-1:0] pin_in,
   output logic [NP-1:0] pin_sync
);

   logic [NP-1:0] stg [STAGES];

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_ovr_sync: STAGES must be at least 2");
   end

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= pin_in;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
         end
      end
   end

   assign pin_sync = stg[STAGES-1];

   if (STAGES == 2) begin : g_chk2
      logic [1:0] warm;
      always_ff @(posedge clk) begin
         if (!rst_n)         warm <= '0;
         else if (warm != 2) warm <= warm + 2'd1;
      end
      // R8: the synchronized level trails the pin by two edges
      assert_sync_latency_R8 : assert property (@(posedge clk) disable iff (!rst_n)
         (warm == 2) |-> (pin_sync == $past(pin_in, 2)));
   end

endmodule

// File: rtl/gpio_ovr_mux.sv
module gpio_ovr_mux #(
   parameter int unsigned   NP           = 8,
   parameter int unsigned   SHUT_PIN     = 7,
   parameter logic [NP-1:0] SPI_PIN_MASK = '0
) (
   input  logic [NP-1:0] dir_q,
   input  logic [NP-1:0] out_q,
   input  logic [NP-1:0] pwm_en,
   input  logic [NP-1:0] pwm_out,
   input  logic          pwm_shut,
   input  logic          spi_en,
   input  logic [NP-1:0] spi_dir,
   input  logic [NP-1:0] spi_out,
   output logic [NP-1:0] pin_oe,
   output logic [NP-1:0] pin_out
);

   for (genvar i = 0; i < NP; i++) begin : g_pin
      logic shut_take;
      logic spi_take;

      if (i == SHUT_PIN) begin : g_shut
         assign shut_take = pwm_en[i] && pwm_shut;
      end else begin : g_plain
         assign shut_take = 1'b0;
      end

      assign spi_take = spi_en && SPI_PIN_MASK[i];

      always_comb begin
         if (shut_take) begin
            pin_oe[i]  = 1'b0;
            pin_out[i] = 1'b0;
         end else if (pwm_en[i]) begin
            pin_oe[i]  = 1'b1;
            pin_out[i] = pwm_out[i];
         end else if (spi_take) begin
            pin_oe[i]  = spi_dir[i];
            pin_out[i] = spi_out[i];
         end else begin
            pin_oe[i]  = dir_q[i];
            pin_out[i] = out_q[i];
         end
      end
   end

endmodule

// File: rtl/gpio_ovr_rdsel.sv
module gpio_ovr_rdsel
   import gpio_ovr_pkg::*;
#(
   parameter int unsigned NP = 8,
   parameter int unsigned DW = 8
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [NP-1:0]     dir_q,
   input  logic [NP-1:0]     out_q,
   input  logic [NP-1:0]     pin_oe,
   input  logic [NP-1:0]     pin_sync,
   output logic [DW-1:0]     rdata
);

   logic [NP-1:0] port_view;

   assign port_view = (out_q & pin_oe) | (pin_sync & ~pin_oe);

   always_comb begin
      rdata = '0;
      unique case (addr)
         REG_DIR:  rdata[NP-1:0] = dir_q;
         REG_OUT:  rdata[NP-1:0] = out_q;
         REG_PORT: rdata[NP-1:0] = port_view;
         default:  rdata[NP-1:0] = pin_sync;
      endcase
   end

endmodule

// File: rtl/gpio_ovr_port.sv
module gpio_ovr_port
   import gpio_ovr_pkg::*;
#(
   parameter int unsigned   NP           = 8,
   parameter int unsigned   DW           = 8,
   parameter int unsigned   SYNC_STAGES  = 2,
   parameter int unsigned   SHUT_PIN     = 7,
   parameter logic [NP-1:0] SPI_PIN_MASK = 8'b0011_1100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DW-1:0]     bus_wdata,
   output logic [DW-1:0]     bus_rdata,
   input  logic [NP-1:0]     pin_in,
   output logic [NP-1:0]     pin_oe,
   output logic [NP-1:0]     pin_out,
   input  logic [NP-1:0]     pwm_en,
   input  logic [NP-1:0]     pwm_out,
   input  logic              pwm_shut,
   input  logic              spi_en,
   input  logic [NP-1:0]     spi_dir,
   input  logic [NP-1:0]     spi_out
);

   localparam logic [NP-1:0] SHUT_BIT = NP'(1) << SHUT_PIN;

   if (NP < 1 || NP > DW) begin : g_bad_width
      $error("gpio_ovr_port: NP must be between 1 and DW");
   end
   if (SHUT_PIN >= NP) begin : g_bad_shut
      $error("gpio_ovr_port: SHUT_PIN out of range");
   end

   logic [NP-1:0] dir_q, out_q, pin_sync;

   gpio_ovr_regs #(.NP(NP), .DW(DW)) i_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .addr  (bus_addr),
      .we    (bus_we),
      .wdata (bus_wdata),
      .dir_q (dir_q),
      .out_q (out_q)
   );

   gpio_ovr_sync #(.NP(NP), .STAGES(SYNC_STAGES)) i_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_in   (pin_in),
      .pin_sync (pin_sync)
   );

   gpio_ovr_mux #(.NP(NP), .SHUT_PIN(SHUT_PIN), .SPI_PIN_MASK(SPI_PIN_MASK)) i_mux (
      .dir_q    (dir_q),
      .out_q    (out_q),
      .pwm_en   (pwm_en),
      .pwm_out  (pwm_out),
      .pwm_shut (pwm_shut),
      .spi_en   (spi_en),
      .spi_dir  (spi_dir),
      .spi_out  (spi_out),
      .pin_oe   (pin_oe),
      .pin_out  (pin_out)
   );

   gpio_ovr_rdsel #(.NP(NP), .DW(DW)) i_rdsel (
      .addr     (bus_addr),
      .dir_q    (dir_q),
      .out_q    (out_q),
      .pin_oe   (pin_oe),
      .pin_sync (pin_sync),
      .rdata    (bus_rdata)
   );

   // R4: every enabled, non-shut PWM channel owns its pin as an output
   assert_pwm_force_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (((pwm_en & ~(SHUT_BIT & {NP{pwm_shut}})) & ~pin_oe) == '0));

   // R5: shutdown turns the designated pin into an input
   assert_shutdown_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (pwm_en[SHUT_PIN] && pwm_shut) |-> !pin_oe[SHUT_PIN]);

   // R7: with no override, direction follows the register
   assert_release_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (!spi_en && pwm_en == '0) |-> (pin_oe == dir_q && (pin_out & pin_oe) == (out_q & dir_q)));

endmodule

// File: tb/test_gpio_ovr_port.sv
module test_gpio_ovr_port;
   import gpio_ovr_pkg::*;

   localparam time TCK = 20ns;

   typedef struct {
      int         sel;
      logic [7:0] exp;
      string      tag;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] bus_addr = '0;
   logic       bus_we = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [7:0] pin_in = '0;
   logic [7:0] pin_oe, pin_out;
   logic [7:0] pwm_en = '0, pwm_out = '0;
   logic       pwm_shut = 1'b0;
   logic       spi_en = 1'b0;
   logic [7:0] spi_dir = '0, spi_out = '0;

   exp_t sb[$];
   int   total = 0;
   int   bad = 0;
   bit   done = 1'b0;

   always #(TCK/2) clk = ~clk;

   gpio_ovr_port i_gpio_ovr_port (
      .clk, .rst_n, .bus_addr, .bus_we, .bus_wdata, .bus_rdata,
      .pin_in, .pin_oe, .pin_out, .pwm_en, .pwm_out, .pwm_shut,
      .spi_en, .spi_dir, .spi_out
   );

   // monitor: compares queued expectations a quarter period after each falling edge
   initial begin
      forever begin
         @(negedge clk);
         #(TCK/4);
         while (sb.size() > 0) begin
            exp_t e;
            logic [7:0] act;
            e = sb.pop_front();
            case (e.sel)
               0:       act = bus_rdata;
               1:       act = pin_oe;
               default: act = pin_out & pin_oe;
            endcase
            total++;
            if (act !== e.exp) begin
               bad++;
               $display("FAIL %s sel=%0d actual=%02h expected=%02h", e.tag, e.sel, act, e.exp);
            end
         end
      end
   end

   task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_we    = 1'b1;
      @(negedge clk);
      bus_we    = 1'b0;
   endtask

   // sel 0: read bus address a; sel 1: pin_oe; sel 2: pin_out masked by pin_oe
   task automatic expect_val(input int sel, input logic [1:0] a, input logic [7:0] v, input string tag);
      exp_t e;
      @(negedge clk);
      bus_addr = a;
      e.sel = sel; e.exp = v; e.tag = tag;
      sb.push_back(e);
   endtask

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      #(TCK * 200000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog R1 actual=hung expected=finished");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // reset state
      expect_val(0, REG_DIR, 8'h00, "R1");
      expect_val(0, REG_OUT, 8'h00, "R2");
      expect_val(1, REG_DIR, 8'h00, "R1");

      // registers and plain direction control
      bus_write(REG_DIR, 8'hA5);
      expect_val(0, REG_DIR, 8'hA5, "R1");
      expect_val(1, REG_DIR, 8'hA5, "R3");
      bus_write(REG_OUT, 8'h3C);
      expect_val(0, REG_OUT, 8'h3C, "R2");
      expect_val(2, REG_DIR, 8'h24, "R3");

      // R8: two-edge synchronizer latency
      begin
         exp_t e;
         @(negedge clk);
         pin_in   = 8'h5A;
         bus_addr = REG_PIN;
         e.sel = 0; e.exp = 8'h00; e.tag = "R8";
         sb.push_back(e);
      end
      expect_val(0, REG_PIN, 8'h00, "R8");
      expect_val(0, REG_PIN, 8'h5A, "R8");

      // R9: port view mixes latch (outputs) and pin level (inputs)
      expect_val(0, REG_PORT, 8'h7E, "R9");

      // R10: read-only locations ignore writes
      bus_write(REG_PORT, 8'hFF);
      bus_write(REG_PIN, 8'h00);
      expect_val(0, REG_DIR, 8'hA5, "R10");
      expect_val(0, REG_OUT, 8'h3C, "R10");

      // R4: PWM takes pins 0 and 1
      @(negedge clk);
      pwm_en = 8'h03; pwm_out = 8'h02;
      expect_val(1, REG_DIR, 8'hA7, "R4");
      expect_val(2, REG_DIR, 8'h26, "R4");
      expect_val(0, REG_PORT, 8'h7C, "R9");

      // R4/R5: designated channel, without and with shutdown
      @(negedge clk);
      pwm_en = 8'h80; pwm_out = 8'h80;
      expect_val(2, REG_DIR, 8'hA4, "R4");
      @(negedge clk);
      pwm_shut = 1'b1;
      expect_val(1, REG_DIR, 8'h25, "R5");
      @(negedge clk);
      pwm_en = 8'h01; pwm_out = 8'h01;
      expect_val(1, REG_DIR, 8'hA5, "R5");

      // R6: SPI claims masked pins 2..5
      @(negedge clk);
      pwm_en = 8'h00; pwm_out = 8'h00; pwm_shut = 1'b0;
      spi_en = 1'b1; spi_dir = 8'h0C; spi_out = 8'hFF;
      expect_val(1, REG_DIR, 8'h8D, "R6");
      expect_val(2, REG_DIR, 8'h0C, "R6");
      @(negedge clk);
      pwm_en = 8'h04;
      expect_val(1, REG_DIR, 8'h8D, "R6");
      expect_val(2, REG_DIR, 8'h08, "R6");

      // R7: release returns control to the registers
      @(negedge clk);
      pwm_en = 8'h00; spi_en = 1'b0;
      expect_val(1, REG_DIR, 8'hA5, "R7");
      expect_val(2, REG_DIR, 8'h24, "R7");

      // R9: all inputs, port view equals pin level
      bus_write(REG_DIR, 8'h00);
      expect_val(0, REG_PORT, 8'h5A, "R9");
      expect_val(1, REG_DIR, 8'h00, "R3");

      repeat (2) @(negedge clk);
      #(TCK/2);
      done = 1'b1;
      finish_run();
   end

endmodule